// File: doc/BRIEF.md
# Synchronous Buck Switch-Timing Sequencer

This block holds the per-cycle digital gate control of a synchronous step-down converter. An oscillator supplies a one-clock pulse at the start of each switching period. Analog comparators supply level flags that the block resynchronises to its own clock before use. These flags report a PWM comparator trip, the current limit, a zero crossing of the inductor current, the sensed current reaching the pulse-skip threshold, feedback below reference, and output below the low-regulation level. From these flags and two mode inputs (forced-PWM and startup-active), the block produces high-side and low-side gate enables. The two enables are separated by a programmable dead time.

In normal operation the high-side switch turns on at each period start and turns off when the PWM comparator trips. The low-side switch then conducts for the rest of the period. When forced-PWM is low, the low-side switch emulates a diode and opens on a zero crossing. At light load the block drops into pulse-skip mode, where the high-side switch fires only when the feedback is low and opens once the current reaches the skip threshold. A low-regulation override bypasses the PWM comparator and runs at maximum duty. The current limit and a maximum-duty window always cut the high-side pulse.

Top module: `buck_switch_ctrl`

## Requirements
- R1: In normal mode, a sampled `cycle_start` raises the internal high-side request. The high-side gate follows one clock later, or after the dead time if the low-side gate was on. The high-side gate drops three clocks after `pwm_trip_in` is first sampled high. The three clocks are two synchroniser stages, the request register and the gate register.
- R2: After the high-side pulse ends, the low-side gate turns on after the dead time. With `fpwm_en` low, the low-side gate drops three clocks after `zcross_in` is first sampled high and stays off until the next period. Without a zero crossing, it stays on until the next period start.
- R3: With `fpwm_en` high, `zcross_in` has no effect, and the low-side gate stays on until the next period start.
- R4: Pulse-skip mode is entered at a period start when `fpwm_en` is low and `above_skip_in` was never seen high (after synchronisation) during the whole previous period. It is left at a period start where `fpwm_en` is high or the effective low-regulation flag is set. After reset the block is in normal mode and treats the previous period as having seen the threshold.
- R5: In pulse-skip mode, the high-side switch turns on at a period start only if `fb_low_in` is high. It turns off when `above_skip_in` arrives. `pwm_trip_in` is ignored.
- R6: `ilim_in` ends the high-side pulse three clocks after it is sampled high, in every mode, including the low-regulation override.
- R7: While `lowreg_in` is high and `startup_act` is low, the high-side switch turns on at every period start regardless of skip mode. `pwm_trip_in` is ignored, so the pulse runs to the maximum-duty limit.
- R8: While `startup_act` is high, `lowreg_in` has no effect, and `pwm_trip_in` ends the pulse as in R1.
- R9: The internal request is cleared at the clock `PERIOD_CLKS - MAXDUTY_OFF_CLKS` after the period start, so the high-side gate drops one clock later.
- R10: A gate enable rises only after both enables have been low for `DEAD_CLKS` clocks. The two enables are never high together.
- R11: All six comparator flags pass through a `SYNC_STAGES`-deep flop chain (two by default) before they affect the switches.
- R12: During reset, both gate enables are low. The first high-side pulse after reset starts one clock after the sampled period start, with no dead-time wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cycle_start | input | 1 | One-clock pulse at each switching period start |
| pwm_trip_in | input | 1 | PWM comparator trip (asynchronous) |
| ilim_in | input | 1 | Cycle-by-cycle current limit (asynchronous) |
| zcross_in | input | 1 | Inductor current zero crossing (asynchronous) |
| above_skip_in | input | 1 | Sensed current at or above the skip threshold (asynchronous) |
| fb_low_in | input | 1 | Feedback below reference (asynchronous) |
| lowreg_in | input | 1 | Output below low-regulation level (asynchronous) |
| fpwm_en | input | 1 | Forced-PWM mode select (synchronous) |
| startup_act | input | 1 | Startup in progress (synchronous) |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
The hardest situation to reach from the ports is pulse-skip mode. Its entry depends on a whole period passing with no threshold sample, and its exit depends on a mode change seen only at the next period start. The stimulus therefore runs an ordered series of periods. A period without threshold pulses arms the entry. An idle skip period with the feedback high confirms that no pulse is produced. Skip pulses then end on the threshold, with a PWM trip placed earlier that must be ignored. Finally, forced-PWM and the low-regulation override each pull the block back out. Every gate edge is predicted to the clock, so dead time, synchroniser delay and mode effects are all checked together.

// File: rtl/buck_ctl_pkg.sv
package buck_ctl_pkg;
  localparam int unsigned NUM_FLAGS = 6;
  localparam int unsigned FLG_PWM    = 0;
  localparam int unsigned FLG_ILIM   = 1;
  localparam int unsigned FLG_ZC     = 2;
  localparam int unsigned FLG_ABOVE  = 3;
  localparam int unsigned FLG_FBLOW  = 4;
  localparam int unsigned FLG_LOWREG = 5;

  // Clock position inside a period from which the high side is held off.
  function automatic int unsigned max_on_pos(int unsigned period, int unsigned off_clks);
    return period - off_clks;
  endfunction

  // Lowest idle count at which a gate may rise so that both stay low for dead clocks.
  function automatic int unsigned gap_threshold(int unsigned dead);
    return (dead > 0) ? dead - 1 : 0;
  endfunction
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/period_timer.sv
module period_timer
  import buck_ctl_pkg::*;
#(
  parameter int unsigned PERIOD_CLKS      = 100,
  parameter int unsigned MAXDUTY_OFF_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_start,
  output logic max_win
);
  localparam int unsigned CW = $clog2(PERIOD_CLKS + 1);
  localparam logic [CW-1:0] ON_LIMIT = CW'(max_on_pos(PERIOD_CLKS, MAXDUTY_OFF_CLKS));
  localparam logic [CW-1:0] SAT      = CW'(PERIOD_CLKS);

  logic [CW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           pos_q <= '0;
    else if (cycle_start) pos_q <= CW'(1);
    else if (pos_q != SAT) pos_q <= pos_q + CW'(1);
  end

  assign max_win = !cycle_start && (pos_q >= ON_LIMIT);
endmodule

// File: rtl/switch_sequencer.sv
module switch_sequencer (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_start,
  input  logic fpwm_en,
  input  logic startup_act,
  input  logic pwm_s,
  input  logic ilim_s,
  input  logic zc_s,
  input  logic above_s,
  input  logic fb_low_s,
  input  logic lowreg_s,
  input  logic max_win,
  output logic hs_req,
  output logic ls_req,
  output logic skip_mode,
  output logic lowreg_eff
);
  logic seen_q;
  logic zc_cut, skip_next, hs_start, hs_stop;

  always_comb begin
    lowreg_eff = lowreg_s && !startup_act;
    zc_cut     = !fpwm_en && zc_s;
    if (fpwm_en || lowreg_eff)     skip_next = 1'b0;
    else if (!skip_mode && !seen_q) skip_next = 1'b1;
    else                            skip_next = skip_mode;
    hs_start = !ilim_s && (lowreg_eff || !skip_next || fb_low_s);
    hs_stop  = ilim_s || max_win || (skip_mode ? above_s : (!lowreg_eff && pwm_s));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skip_mode <= 1'b0;
      seen_q    <= 1'b1;
      hs_req    <= 1'b0;
      ls_req    <= 1'b0;
    end else if (cycle_start) begin
      skip_mode <= skip_next;
      seen_q    <= above_s;
      hs_req    <= hs_start;
      ls_req    <= hs_start ? 1'b0 : (ls_req && !zc_cut);
    end else begin
      seen_q <= seen_q || above_s;
      if (hs_req && hs_stop) begin
        hs_req <= 1'b0;
        ls_req <= !zc_cut;
      end else if (zc_cut) begin
        ls_req <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dead_time_stage.sv
module dead_time_stage
  import buck_ctl_pkg::*;
#(
  parameter int unsigned DEAD_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_req,
  input  logic ls_req,
  output logic hs_gate,
  output logic ls_gate
);
  localparam int unsigned QW = $clog2(DEAD_CLKS + 1);
  localparam logic [QW-1:0] QMAX = QW'(DEAD_CLKS);
  localparam logic [QW-1:0] QLIM = QW'(gap_threshold(DEAD_CLKS));

  logic [QW-1:0] quiet_q;
  logic both_low, gap_ok;

  assign both_low = !hs_gate && !ls_gate;
  assign gap_ok   = both_low && (quiet_q >= QLIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_gate <= 1'b0;
      ls_gate <= 1'b0;
      quiet_q <= QMAX;
    end else begin
      hs_gate <= hs_req && (hs_gate || (gap_ok && !ls_req));
      ls_gate <= ls_req && !hs_req && (ls_gate || gap_ok);
      if (!both_low)            quiet_q <= '0;
      else if (quiet_q != QMAX) quiet_q <= quiet_q + QW'(1);
    end
  end
endmodule

// File: rtl/buck_switch_ctrl.sv
module buck_switch_ctrl
  import buck_ctl_pkg::*;
#(
  parameter int unsigned PERIOD_CLKS      = 100,
  parameter int unsigned MAXDUTY_OFF_CLKS = 8,
  parameter int unsigned DEAD_CLKS        = 3,
  parameter int unsigned SYNC_STAGES      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_start,
  input  logic pwm_trip_in,
  input  logic ilim_in,
  input  logic zcross_in,
  input  logic above_skip_in,
  input  logic fb_low_in,
  input  logic lowreg_in,
  input  logic fpwm_en,
  input  logic startup_act,
  output logic hs_gate,
  output logic ls_gate
);
  logic [NUM_FLAGS-1:0] flags_raw, flags_s;
  logic hs_req, ls_req, skip_mode, lowreg_eff, max_win;
  logic ilim_s;

  always_comb begin
    flags_raw             = '0;
    flags_raw[FLG_PWM]    = pwm_trip_in;
    flags_raw[FLG_ILIM]   = ilim_in;
    flags_raw[FLG_ZC]     = zcross_in;
    flags_raw[FLG_ABOVE]  = above_skip_in;
    flags_raw[FLG_FBLOW]  = fb_low_in;
    flags_raw[FLG_LOWREG] = lowreg_in;
  end

  assign ilim_s = flags_s[FLG_ILIM];

  flag_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(flags_raw), .dout(flags_s)
  );

  period_timer #(.PERIOD_CLKS(PERIOD_CLKS), .MAXDUTY_OFF_CLKS(MAXDUTY_OFF_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .max_win(max_win)
  );

  switch_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
    .fpwm_en(fpwm_en), .startup_act(startup_act),
    .pwm_s(flags_s[FLG_PWM]), .ilim_s(ilim_s), .zc_s(flags_s[FLG_ZC]),
    .above_s(flags_s[FLG_ABOVE]), .fb_low_s(flags_s[FLG_FBLOW]),
    .lowreg_s(flags_s[FLG_LOWREG]), .max_win(max_win),
    .hs_req(hs_req), .ls_req(ls_req), .skip_mode(skip_mode), .lowreg_eff(lowreg_eff)
  );

  dead_time_stage #(.DEAD_CLKS(DEAD_CLKS)) u_dead (
    .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .ls_req(ls_req),
    .hs_gate(hs_gate), .ls_gate(ls_gate)
  );
endmodule

// File: rtl/buck_switch_ctrl_chk.sv
module buck_switch_ctrl_chk #(
  parameter int unsigned DEAD_CLKS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic cycle_start,
  input logic fpwm_en,
  input logic hs_gate,
  input logic ls_gate,
  input logic hs_req,
  input logic ls_req,
  input logic ilim_s,
  input logic max_win,
  input logic lowreg_eff,
  input logic skip_mode
);
  localparam int unsigned LW = $clog2(DEAD_CLKS + 1);
  localparam logic [LW-1:0] LMAX = LW'(DEAD_CLKS);
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  low_cnt <= LMAX;
    else if (hs_gate || ls_gate) low_cnt <= '0;
    else if (low_cnt != LMAX)    low_cnt <= low_cnt + LW'(1);
  end

  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  p_hs_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> low_cnt >= LMAX);

  p_ls_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> low_cnt >= LMAX);

  p_start_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_req) |-> $past(cycle_start));

  p_ilim_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_s |=> !hs_req);

  p_duty_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    max_win |=> !hs_req);

  p_lowreg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lowreg_eff && !skip_mode && hs_req && !ilim_s && !max_win && !cycle_start) |=> hs_req);

  p_fpwm_ls_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fpwm_en && ls_req && !cycle_start) |=> ls_req);
endmodule

bind buck_switch_ctrl buck_switch_ctrl_chk #(.DEAD_CLKS(DEAD_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .fpwm_en(fpwm_en),
  .hs_gate(hs_gate), .ls_gate(ls_gate), .hs_req(hs_req), .ls_req(ls_req),
  .ilim_s(ilim_s), .max_win(max_win), .lowreg_eff(lowreg_eff), .skip_mode(skip_mode)
);

// File: tb/test_buck_switch_ctrl.sv
`timescale 1ns/1ps
module test_buck_switch_ctrl;
  localparam int P = 40;
  localparam int OFF = 6;
  localparam int D = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cycle_start = 0, pwm_trip_in = 0, ilim_in = 0, zcross_in = 0;
  logic above_skip_in = 0, fb_low_in = 0, lowreg_in = 0, fpwm_en = 0, startup_act = 0;
  logic hs_gate, ls_gate;

  int checks = 0;
  int errors = 0;
  int edge_n = 0;
  int hs_rises = 0;
  bit done = 0;

  bit q_gate[$];
  bit q_lvl[$];
  int q_edge[$];
  string q_tag[$];

  bit m_skip = 0, m_seen = 1, m_ls = 0, m_first = 1;
  string m_ls_tag = "R10";

  always #5 clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  buck_switch_ctrl #(.PERIOD_CLKS(P), .MAXDUTY_OFF_CLKS(OFF), .DEAD_CLKS(D), .SYNC_STAGES(2))
    i_buck_switch_ctrl (
      .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .pwm_trip_in(pwm_trip_in),
      .ilim_in(ilim_in), .zcross_in(zcross_in), .above_skip_in(above_skip_in),
      .fb_low_in(fb_low_in), .lowreg_in(lowreg_in), .fpwm_en(fpwm_en),
      .startup_act(startup_act), .hs_gate(hs_gate), .ls_gate(ls_gate));

  function automatic string gname(bit g);
    return g ? "ls_gate" : "hs_gate";
  endfunction

  task automatic push(bit g, bit l, int e, string t);
    q_gate.push_back(g); q_lvl.push_back(l); q_edge.push_back(e); q_tag.push_back(t);
  endtask

  task automatic observe(bit g, bit l);
    checks++;
    if (q_edge.size() == 0) begin
      errors++;
      $display("FAIL unexpected: %s went %0d at edge %0d, expected no change", gname(g), l, edge_n);
    end else begin
      bit eg = q_gate.pop_front();
      bit el = q_lvl.pop_front();
      int ee = q_edge.pop_front();
      string et = q_tag.pop_front();
      if (eg != g || el != l || ee != edge_n) begin
        errors++;
        $display("FAIL %s: %s went %0d at edge %0d, expected %s to %0d at edge %0d",
                 et, gname(g), l, edge_n, gname(eg), el, ee);
      end
    end
  endtask

  // Monitor: every gate change is popped against the scoreboard.
  bit hs_prev = 0, ls_prev = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hs_gate != hs_prev) begin
        if (hs_gate) hs_rises++;
        observe(1'b0, hs_gate);
      end
      if (ls_gate != ls_prev) observe(1'b1, ls_gate);
    end
    hs_prev = hs_gate;
    ls_prev = ls_gate;
  end

  task automatic check_val(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
    end
  endtask

  // One switching period. Pulse positions are clocks after the period start (-1 = none).
  task automatic cyc(bit lr, bit fb, bit fp, bit su, int trip_at, int ilim_at, int above_at, int zc_at);
    int s, c, rises0;
    bit lr_eff, nskip, hs_on;
    string tag;
    @(negedge clk);
    lowreg_in = lr; fb_low_in = fb; fpwm_en = fp; startup_act = su;
    repeat (3) @(negedge clk);
    s = edge_n + 1;
    rises0 = hs_rises;
    // expected behaviour from the requirements
    lr_eff = lr && !su;
    if (fp || lr_eff)            nskip = 0;
    else if (!m_skip && !m_seen) nskip = 1;
    else                         nskip = m_skip;
    hs_on = lr_eff || !nskip || fb;
    if (hs_on) begin
      if (m_ls) begin
        push(1, 0, s + 1, m_ls_tag);
        push(0, 1, s + 1 + D, "R10");
      end else begin
        push(0, 1, s + 1, m_first ? "R12" : "R1");
      end
      c = s + P - OFF; tag = lr_eff ? "R7" : "R9";
      if (!nskip && !lr_eff && trip_at >= 0 && s + trip_at + 2 < c) begin
        c = s + trip_at + 2; tag = (lr && su) ? "R8" : "R1 R11";
      end
      if (nskip && above_at >= 0 && s + above_at + 2 < c) begin
        c = s + above_at + 2; tag = "R5";
      end
      if (ilim_at >= 0 && s + ilim_at + 2 < c) begin
        c = s + ilim_at + 2; tag = "R6";
      end
      push(0, 0, c + 1, tag);
      push(1, 1, c + 1 + D, "R10");
      if (!fp && zc_at >= 0) begin
        push(1, 0, s + zc_at + 3, "R2");
        m_ls = 0;
      end else begin
        m_ls = 1;
        m_ls_tag = (fp && zc_at >= 0) ? "R3" : "R2";
      end
      m_first = 0;
    end
    m_skip = nskip;
    m_seen = (above_at >= 0);
    // drive the period
    cycle_start = 1;
    for (int k = 0; k < P; k++) begin
      if (k == 1) cycle_start = 0;
      pwm_trip_in   = (trip_at  >= 0) && (k >= trip_at)  && (k < trip_at + 3);
      ilim_in       = (ilim_at  >= 0) && (k >= ilim_at)  && (k < ilim_at + 3);
      above_skip_in = (above_at >= 0) && (k >= above_at) && (k < above_at + 3);
      zcross_in     = (zc_at    >= 0) && (k >= zc_at)    && (k < zc_at + 3);
      @(negedge clk);
    end
    cycle_start = 0; pwm_trip_in = 0; ilim_in = 0; above_skip_in = 0; zcross_in = 0;
    if (!hs_on) check_val("R4 R5 skip period without pulse", hs_rises - rises0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check_val("R12 hs_gate in reset", hs_gate, 0);
    check_val("R12 ls_gate in reset", ls_gate, 0);
    rst_n = 1;
    @(negedge clk);
    check_val("R12 hs_gate after reset", hs_gate, 0);
    cyc(0, 0, 1, 0, 10, -1, 5, -1);  // R12 first pulse, R1 trip
    cyc(0, 0, 1, 0, 15, -1, 5, 25);  // R3 zero cross ignored
    cyc(0, 0, 1, 0, -1, -1, 5, -1);  // R9 maximum duty
    cyc(0, 0, 1, 0, 20, 8, 5, -1);   // R6 current limit first
    cyc(1, 0, 1, 0, 10, -1, 5, -1);  // R7 trip bypassed
    cyc(1, 0, 1, 0, -1, 12, 5, -1);  // R6 under override
    cyc(1, 0, 1, 1, 10, -1, 5, -1);  // R8 startup masks override
    cyc(0, 0, 0, 0, 10, -1, 5, 25);  // R2 zero-cross cutoff
    cyc(0, 0, 0, 0, 10, -1, -1, 25); // no threshold seen: arms R4
    cyc(0, 0, 0, 0, 10, -1, -1, -1); // R4 skip entered, fb high -> no pulse
    cyc(0, 1, 0, 0, 5, -1, 15, 28);  // R5 pulse, trip ignored
    cyc(0, 1, 0, 0, -1, -1, 8, -1);  // R5 pulse ends on threshold
    cyc(0, 0, 1, 0, 10, -1, -1, -1); // R4 exit through forced-PWM
    cyc(0, 1, 0, 0, 10, -1, 12, 25); // R4 re-entry, R5 threshold wins over trip
    cyc(1, 0, 0, 0, 10, -1, 5, -1);  // R4 exit through override, R7
    repeat (10) @(negedge clk);
    check_val("R10 scoreboard drained", q_edge.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule